// File: doc/BRIEF.md
# EDO DRAM Access and Refresh Controller

This block connects a simple request/ready host port to the pins of an extended-data-out DRAM. The array has 2048 rows of 1024 bytes by default. A host request carries a flat byte address, a read/write flag and write data. The controller splits the address into a row part (upper bits) and a column part (lower bits) and multiplexes them onto one strobed address bus. It opens the row with the row strobe and then runs one column-strobe cycle per access.

After an access the row is left open. A later request to the same row therefore costs only a column-strobe cycle (page mode). A request to another row first closes the row and waits out a precharge time. The row strobe is never held low longer than a set limit: the controller stops taking page hits once another one would run past that limit, and then closes the row. The output data of the device stays valid after the column strobe rises, so read data is taken at the end of the column-high phase.

A free-running timer raises a refresh request at a fixed interval. When a refresh is pending, the controller finishes the column cycle in progress, closes any open row and runs a column-before-row refresh cycle before it accepts more host work. Every timing value is a count of clock cycles set by a parameter.

Top module: `edo_dram_ctrl`

## Requirements
- R1: While reset is held and after it is released, with no request, ras_n, cas_n, we_n and oe_n are 1, rvalid is 0 and ready is 0.
- R2: On the row strobe's falling edge, ma carries address bits [ROW_W+COL_W-1:COL_W]. On the column strobe's falling edge, ma carries address bits [COL_W-1:0], with ma bits above COL_W-1 driven to 0.
- R3: ma does not change on the clock edge where ras_n falls, nor on the clock edge where cas_n falls.
- R4: In a write, we_n is 0, oe_n is 1 and dq carries the write data while cas_n is low.
- R5: In a read, oe_n is 0, we_n is 1 and the controller leaves dq undriven while cas_n is low. rdata holds the dq value taken in the last cycle of the column-high phase, and rvalid is high for exactly one cycle.
- R6: A request to the open row is accepted without ras_n rising. rvalid appears 1+T_CASL+T_CASH clock edges after the accepting edge.
- R7: A request accepted with no row open has its rvalid T_RCD+T_CASL+T_CASH+2 edges after the accepting edge. Any high period of ras_n lasts at least T_RP cycles.
- R8: ras_n never stays low for more than RAS_MAX consecutive cycles.
- R9: In a refresh, cas_n falls while ras_n is high and stays low for at least T_CSR cycles before ras_n falls, with we_n held at 1.
- R10: A pending refresh takes priority over host requests, so that the gap between refresh starts never exceeds REF_INT+T_RCD+T_CASL+T_CASH+T_RP+8 cycles, even under continuous traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Host request, held until accepted |
| ready | output | 1 | Request accepted on this clock edge when high with req |
| wr | input | 1 | 1 for write, 0 for read |
| addr | input | ROW_W+COL_W | Flat byte address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data |
| rvalid | output | 1 | One-cycle pulse marking new rdata |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| ma | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dq | inout | DW | Bidirectional data bus |

## Verification
Read results are timed from the accepting edge. A page hit is due 1+T_CASL+T_CASH edges later and an access from a closed row T_RCD+T_CASL+T_CASH+2 edges later. The bench notes whether ras_n was high when ready was seen, picks the matching count, counts edges up to rvalid and compares. Every sample is taken on the falling clock edge, after the registers that feed it have settled. Pin rules (address stability, precharge length, refresh lead and interval, row-strobe limit) are checked by a monitor on every falling clock edge and at every strobe edge. The full address space of a small configuration is written and then read back in a scattered order, so page hits, row misses and refresh all occur.

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl #(
  parameter int ROW_W   = 11,
  parameter int COL_W   = 10,
  parameter int DW      = 8,
  parameter int T_RP    = 3,
  parameter int T_RCD   = 2,
  parameter int T_CASL  = 1,
  parameter int T_CASH  = 1,
  parameter int T_CSR   = 1,
  parameter int T_RFW   = 5,
  parameter int RAS_MAX = 10000,
  parameter int REF_INT = 1560
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       req,
  output logic                                       ready,
  input  logic                                       wr,
  input  logic [ROW_W+COL_W-1:0]                     addr,
  input  logic [DW-1:0]                              wdata,
  output logic [DW-1:0]                              rdata,
  output logic                                       rvalid,
  output logic                                       ras_n,
  output logic                                       cas_n,
  output logic                                       we_n,
  output logic                                       oe_n,
  output logic [(ROW_W>COL_W?ROW_W:COL_W)-1:0]       ma,
  inout  wire  [DW-1:0]                              dq
);

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int AW   = ROW_W + COL_W;
  localparam int MA_W = imax(ROW_W, COL_W);
  localparam int TMAX = imax(imax(imax(T_RP, T_RCD), imax(T_CASL, T_CASH)), imax(T_CSR, T_RFW));
  localparam int CW   = $clog2(TMAX + 1);
  localparam int RCW  = $clog2(RAS_MAX + 1);
  localparam int REFW = $clog2(REF_INT + 1);
  localparam int PAGE = 2 + T_CASL + T_CASH;

  localparam logic [CW-1:0]   C_RP   = CW'(T_RP - 1);
  localparam logic [CW-1:0]   C_RCD  = CW'(T_RCD - 1);
  localparam logic [CW-1:0]   C_CASL = CW'(T_CASL - 1);
  localparam logic [CW-1:0]   C_CASH = CW'(T_CASH - 1);
  localparam logic [CW-1:0]   C_CSR  = CW'(T_CSR - 1);
  localparam logic [CW-1:0]   C_RFW  = CW'(T_RFW - 1);
  localparam logic [RCW-1:0]  RAS_LIM  = RCW'(RAS_MAX);
  localparam logic [RCW-1:0]  PAGE_LIM = RCW'(RAS_MAX - PAGE);
  localparam logic [REFW-1:0] REF_LD   = REFW'(REF_INT - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_ASU, S_RCD, S_CSU, S_CAS, S_CASH, S_OPEN, S_PRE, S_RFC, S_RFR, S_RFP
  } st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [ROW_W-1:0] open_row;
  logic [COL_W-1:0] col_q;
  logic             wr_q;
  logic [DW-1:0]    dq_o;
  logic             dq_en;
  logic [RCW-1:0]   ras_cnt;
  logic [REFW-1:0]  ref_cnt;
  logic             ref_pend;

  wire [ROW_W-1:0] req_row = addr[AW-1:COL_W];
  wire [COL_W-1:0] req_col = addr[COL_W-1:0];
  wire             cnt_done = (cnt == '0);
  wire             hit_ok = (st == S_OPEN) && (req_row == open_row) && (ras_cnt < PAGE_LIM);

  assign ready = req && !ref_pend && ((st == S_IDLE) || hit_ok);
  assign dq    = dq_en ? dq_o : 'z;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_cnt  <= REF_LD;
      ref_pend <= 1'b0;
    end else begin
      ref_cnt  <= (ref_cnt == '0) ? REF_LD : ref_cnt - 1'b1;
      ref_pend <= (ref_cnt == '0) || (ref_pend && (st != S_IDLE));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ras_n) ras_cnt <= '0;
    else                 ras_cnt <= ras_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      ras_n    <= 1'b1;
      cas_n    <= 1'b1;
      we_n     <= 1'b1;
      oe_n     <= 1'b1;
      dq_en    <= 1'b0;
      dq_o     <= '0;
      ma       <= '0;
      open_row <= '0;
      col_q    <= '0;
      wr_q     <= 1'b0;
      rdata    <= '0;
      rvalid   <= 1'b0;
    end else begin
      rvalid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (ref_pend) begin
            cas_n <= 1'b0;
            cnt   <= C_CSR;
            st    <= S_RFC;
          end else if (req) begin
            ma       <= MA_W'(req_row);
            open_row <= req_row;
            col_q    <= req_col;
            wr_q     <= wr;
            dq_o     <= wdata;
            st       <= S_ASU;
          end
        end
        S_ASU: begin
          ras_n <= 1'b0;
          cnt   <= C_RCD;
          st    <= S_RCD;
        end
        S_RCD: begin
          if (cnt_done) begin
            ma    <= MA_W'(col_q);
            we_n  <= !wr_q;
            oe_n  <= wr_q;
            dq_en <= wr_q;
            st    <= S_CSU;
          end else cnt <= cnt - 1'b1;
        end
        S_CSU: begin
          cas_n <= 1'b0;
          cnt   <= C_CASL;
          st    <= S_CAS;
        end
        S_CAS: begin
          if (cnt_done) begin
            cas_n <= 1'b1;
            cnt   <= C_CASH;
            st    <= S_CASH;
          end else cnt <= cnt - 1'b1;
        end
        S_CASH: begin
          if (cnt_done) begin
            if (!wr_q) begin
              rdata  <= dq;
              rvalid <= 1'b1;
            end
            oe_n  <= 1'b1;
            we_n  <= 1'b1;
            dq_en <= 1'b0;
            st    <= S_OPEN;
          end else cnt <= cnt - 1'b1;
        end
        S_OPEN: begin
          if (ready) begin
            ma    <= MA_W'(req_col);
            col_q <= req_col;
            wr_q  <= wr;
            dq_o  <= wdata;
            we_n  <= !wr;
            oe_n  <= wr;
            dq_en <= wr;
            st    <= S_CSU;
          end else if (ref_pend || req || (ras_cnt >= PAGE_LIM)) begin
            ras_n <= 1'b1;
            cnt   <= C_RP;
            st    <= S_PRE;
          end
        end
        S_PRE: begin
          if (cnt_done) st <= S_IDLE;
          else          cnt <= cnt - 1'b1;
        end
        S_RFC: begin
          if (cnt_done) begin
            ras_n <= 1'b0;
            cnt   <= C_RFW;
            st    <= S_RFR;
          end else cnt <= cnt - 1'b1;
        end
        S_RFR: begin
          if (cnt_done) begin
            ras_n <= 1'b1;
            cas_n <= 1'b1;
            cnt   <= C_RP;
            st    <= S_RFP;
          end else cnt <= cnt - 1'b1;
        end
        S_RFP: begin
          if (cnt_done) st <= S_IDLE;
          else          cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_RAS_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $stable(ma)); // R3
  AST_CAS_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> $stable(ma)); // R3
  AST_RAS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> (ras_cnt < RAS_LIM)); // R8
  AST_CBR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> (!$past(cas_n) && we_n)); // R9
  AST_WR_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> oe_n); // R4
  AST_RD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !dq_en); // R5
  AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid); // R5
  AST_PRE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |=> ras_n); // R7
  AST_REF_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_OPEN) && ref_pend) |=> ras_n); // R10

endmodule

// File: tb/tb_edo_dram_ctrl.sv
module tb_edo_dram_ctrl;
  localparam int CLK_P   = 10;
  localparam int ROW_W   = 4;
  localparam int COL_W   = 3;
  localparam int DW      = 8;
  localparam int T_RP    = 2;
  localparam int T_RCD   = 2;
  localparam int T_CASL  = 2;
  localparam int T_CASH  = 1;
  localparam int T_CSR   = 1;
  localparam int T_RFW   = 3;
  localparam int RAS_MAX = 40;
  localparam int REF_INT = 300;
  localparam int AW      = ROW_W + COL_W;
  localparam int MA_W    = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int LAT_HIT = 1 + T_CASL + T_CASH;
  localparam int LAT_CLS = 2 + T_RCD + T_CASL + T_CASH;
  localparam int REF_BND = REF_INT + T_RCD + T_CASL + T_CASH + T_RP + 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic wr_i = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic ready, rvalid, ras_n, cas_n, we_n, oe_n;
  logic [DW-1:0] rdata;
  logic [MA_W-1:0] ma;
  wire  [DW-1:0] dq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  edo_dram_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DW(DW), .T_RP(T_RP), .T_RCD(T_RCD),
    .T_CASL(T_CASL), .T_CASH(T_CASH), .T_CSR(T_CSR), .T_RFW(T_RFW),
    .RAS_MAX(RAS_MAX), .REF_INT(REF_INT)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .ready(ready), .wr(wr_i),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n), .ma(ma), .dq(dq)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a * 13 + 7);
  endfunction

  logic [DW-1:0]    mem [0:(1<<AW)-1];
  logic [ROW_W-1:0] m_row = '0;
  logic [COL_W-1:0] m_col = '0;

  initial for (int i = 0; i < (1<<AW); i++) mem[i] = '0;

  always @(negedge ras_n) if (cas_n) m_row = ma[ROW_W-1:0];

  always @(negedge cas_n) if (!ras_n) begin
    m_col = ma[COL_W-1:0];
    chk(ma[MA_W-1:COL_W] == '0, "R2 column upper bits", int'(ma), int'(ma[COL_W-1:0]));
    if (!we_n) mem[{m_row, m_col}] = dq;
  end

  assign dq = (!oe_n && we_n && !ras_n) ? mem[{m_row, m_col}] : 'z;

  int  lo_run = 0, hi_run = 0, max_low = 0, lead = 0, nref = 0, last_ref = 0;
  bit  have_ref = 1'b0, prev_ras = 1'b1, prev_cas = 1'b1;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<=60000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (!ras_n) begin
      lo_run++;
      if (lo_run > max_low) max_low = lo_run;
    end else lo_run = 0;
    if (prev_ras && !ras_n) begin
      if (cas_n) chk(hi_run >= T_RP, "R7 precharge", hi_run, T_RP);
      else       chk(lead >= T_CSR && we_n, "R9 refresh lead", lead, T_CSR);
    end
    if (ras_n) hi_run++; else hi_run = 0;
    if (prev_cas && !cas_n && ras_n) begin
      nref++;
      if (have_ref) chk(cyc - last_ref <= REF_BND, "R10 refresh gap", cyc - last_ref, REF_BND);
      last_ref = cyc;
      have_ref = 1'b1;
    end
    if (!cas_n && ras_n) lead++; else if (cas_n) lead = 0;
    prev_ras = ras_n;
    prev_cas = cas_n;
  end

  task automatic do_wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    req = 1'b1; wr_i = 1'b1; addr = AW'(a); wdata = d;
    while (!ready) @(negedge clk);
    @(negedge clk);
    req = 1'b0;
    while (cas_n) @(negedge clk);
    chk(dq == d && oe_n && !we_n, "R4 write pins", int'(dq), int'(d));
    while (!we_n) @(negedge clk);
  endtask

  task automatic do_rd(input int a, output logic [DW-1:0] q, output int lat, output bit closed);
    bit pins_ok = 1'b1;
    @(negedge clk);
    req = 1'b1; wr_i = 1'b0; addr = AW'(a);
    while (!ready) @(negedge clk);
    closed = ras_n;
    @(negedge clk);
    req = 1'b0;
    lat = 0;
    while (!rvalid) begin
      if (!cas_n && !(!oe_n && we_n)) pins_ok = 1'b0;
      @(negedge clk);
      lat++;
    end
    q = rdata;
    chk(pins_ok, "R5 read pins", int'(pins_ok), 1);
    @(negedge clk);
    chk(!rvalid, "R5 rvalid pulse", int'(rvalid), 0);
  endtask

  task automatic wait_ref();
    int c = nref;
    while (nref == c) @(negedge clk);
  endtask

  initial begin
    logic [DW-1:0] q;
    int lat;
    bit closed;
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n && oe_n && !rvalid && !ready, "R1 in reset",
        int'({ras_n, cas_n, we_n, oe_n, rvalid, ready}), 6'b111100);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ras_n && cas_n && we_n && oe_n && !rvalid && !ready, "R1 after reset",
        int'({ras_n, cas_n, we_n, oe_n, rvalid, ready}), 6'b111100);

    wait_ref();
    do_wr(8'h15, 8'hA5);
    do_rd(8'h15, q, lat, closed);
    chk(q == 8'hA5, "R5 read after write", int'(q), 8'hA5);
    chk(!closed, "R6 open row reused", int'(closed), 0);
    chk(lat == LAT_HIT, "R6 hit latency", lat, LAT_HIT);
    do_rd(8'h13, q, lat, closed);
    chk(!closed && lat == LAT_HIT, "R6 second hit", lat, LAT_HIT);
    do_rd(8'h2B, q, lat, closed);
    chk(closed, "R7 miss closes row", int'(closed), 1);
    chk(lat == LAT_CLS, "R7 closed-row latency", lat, LAT_CLS);

    for (int a = 0; a < (1<<AW); a++) do_wr(a, pat(a));
    for (int i = 0; i < (1<<AW); i++) begin
      int a = (i * 37) % (1<<AW);
      do_rd(a, q, lat, closed);
      chk(q == pat(a), "R2 data at address", int'(q), int'(pat(a)));
      chk(lat == (closed ? LAT_CLS : LAT_HIT), closed ? "R7 latency" : "R6 latency",
          lat, closed ? LAT_CLS : LAT_HIT);
    end

    for (int i = 0; i < 24; i++) begin
      int a = 6 * (1<<COL_W) + (i % (1<<COL_W));
      do_rd(a, q, lat, closed);
      chk(q == pat(a), "R8 burst data", int'(q), int'(pat(a)));
    end

    repeat (800) @(negedge clk);
    chk(max_low <= RAS_MAX, "R8 row strobe window", max_low, RAS_MAX);
    chk(nref >= 8, "R9 refresh count", nref, 8);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule